// File: doc/BRIEF.md
# UART Hardware Flow Control Unit

This block holds the automatic modem-line flow control for one UART channel. It sits between a receive FIFO, a transmit character engine and four active-low modem lines. On the receive side it drives two throttle outputs, `rts_n` and `dtr_n`. Each output compares the receive FIFO fill count against its own pair of thresholds, an upper one and a lower one, so the output has hysteresis. When its automation is switched off, the output follows a bit set by software.

On the transmit side, the character engine asks to begin each character with `tx_start_req`. The block grants the request on `tx_start_ok` only if every enabled permission line is asserted. The permission lines are `cts_n` and `dsr_n`, each passed through a two-flop synchronizer first. The decision is made only at a character boundary. A character that has started always runs until `tx_char_done`, so a line that drops mid-character does not cut it short. In-band flow characters, marked with `is_flow_char`, bypass the permission lines. The serial line itself idles high, and each character is framed by a start bit and a stop bit. Both belong to the serializer, which is outside this block.

Each receive throttle is a two-state machine: RX_GO (output low, sender may transmit) and RX_STOP (output high). RX_GO moves to RX_STOP when the level is at or above the upper threshold. RX_STOP moves to RX_GO when the level is below both thresholds. With automation off, the state is forced from the software bit. The transmit gate is a two-state machine: TX_IDLE and TX_BUSY. TX_IDLE moves to TX_BUSY on a granted request. TX_BUSY returns to TX_IDLE on `tx_char_done`.

Top module: `uart_flow_ctrl`

## Requirements
- R1: During and right after reset, `rts_n` and `dtr_n` are 1, `tx_busy` is 0, and `tx_start_ok` is 0 while no request is present.
- R2: With automation on, a throttle output (RTS or DTR, each with its own thresholds) is 1 one clock edge after the edge that samples a level greater than or equal to its upper threshold.
- R3: With automation on, a throttle output is 0 one edge after the edge that samples a level below both its lower and its upper threshold.
- R4: With automation on, a throttle output keeps its value when the sampled level is at or above the lower threshold and below the upper threshold.
- R5: With automation off, a throttle output equals the inverse of its software bit one edge later (software bit 1 gives output 0). The FIFO level has no effect.
- R6: In TX_IDLE, with a request present and `is_flow_char` at 0, `tx_start_ok` is 1 exactly when every enabled permission line, after two synchronizing edges, is low. A line whose automation is off counts as asserted.
- R7: A granted request (`tx_start_req` and `tx_start_ok` both 1 at an edge) sets `tx_busy` at that edge. `tx_start_ok` stays 0 while `tx_busy` is 1. An edge with `tx_char_done` at 1 clears `tx_busy`.
- R8: In TX_IDLE, a request with `is_flow_char` at 1 gets `tx_start_ok` at 1 whatever the permission lines are.
- R9: While `tx_busy` is 1, deasserting `cts_n` or `dsr_n` does not clear `tx_busy`. It stays 1 until `tx_char_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_level | input | LVL_W | Receive FIFO fill count |
| rts_auto_en | input | 1 | RTS automation enable |
| rts_upper | input | LVL_W | RTS upper (stop) threshold |
| rts_lower | input | LVL_W | RTS lower (resume) threshold |
| rts_sw | input | 1 | Software RTS bit, 1 asserts (drives low) |
| dtr_auto_en | input | 1 | DTR automation enable |
| dtr_upper | input | LVL_W | DTR upper threshold |
| dtr_lower | input | LVL_W | DTR lower threshold |
| dtr_sw | input | 1 | Software DTR bit, 1 asserts |
| cts_auto_en | input | 1 | CTS gating enable |
| dsr_auto_en | input | 1 | DSR gating enable |
| cts_n | input | 1 | Clear-to-send line, asynchronous, active low |
| dsr_n | input | 1 | Data-set-ready line, asynchronous, active low |
| tx_start_req | input | 1 | Character engine asks to begin a character |
| is_flow_char | input | 1 | Requested character is an in-band flow character |
| tx_char_done | input | 1 | Current character has finished |
| tx_start_ok | output | 1 | Grant to begin the requested character |
| tx_busy | output | 1 | A granted character is in progress |
| rts_n | output | 1 | RTS output, active low |
| dtr_n | output | 1 | DTR output, active low |

## Verification
The throttle outputs are registered. The expected value is computed from the inputs the bench drives before an edge, and the bench compares it at the falling edge after that rising edge. `tx_start_ok` is combinational on the request lines, so it is sampled one time step after the inputs change. A change on `cts_n` or `dsr_n`, however, reaches it only after two rising edges, and the bench waits exactly those two edges before checking. `tx_busy` is checked at the falling edge after the edge that granted the request or saw `tx_char_done`. The permission lines are dropped during that window, and busy must persist across it.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;
    typedef enum logic {
        RX_GO   = 1'b0,
        RX_STOP = 1'b1
    } rx_state_t;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_BUSY = 1'b1
    } tx_state_t;
endpackage

// File: rtl/flow_sync.sv
module flow_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '1;
        else        chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '1;
            else        chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/flow_rx_throttle.sv
module flow_rx_throttle
    import uart_flow_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] upper,
    input  logic [LVL_W-1:0] lower,
    input  logic             sw_assert,
    output logic             pin_n
);
    rx_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!auto_en) begin
            state_d = sw_assert ? RX_GO : RX_STOP;
        end else begin
            unique case (state_q)
                RX_GO:   if (level >= upper) state_d = RX_STOP;
                RX_STOP: if (level < upper && level < lower) state_d = RX_GO;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        pin_n = (state_q == RX_STOP);
    end

    AST_THR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        auto_en && level >= upper |=> pin_n); // R2
    AST_THR_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        auto_en && level < lower && level < upper |=> !pin_n); // R3
    AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        auto_en && level >= lower && level < upper |=> $stable(pin_n)); // R4
    AST_SW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> pin_n == !$past(sw_assert)); // R5
endmodule

// File: rtl/flow_tx_gate.sv
module flow_tx_gate
    import uart_flow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cts_en,
    input  logic dsr_en,
    input  logic cts_n_s,
    input  logic dsr_n_s,
    input  logic tx_start_req,
    input  logic is_flow_char,
    input  logic tx_char_done,
    output logic tx_start_ok,
    output logic tx_busy
);
    tx_state_t state_q, state_d;
    logic      lines_clear;

    assign lines_clear = (!cts_en || !cts_n_s) && (!dsr_en || !dsr_n_s);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (tx_start_req && (is_flow_char || lines_clear)) state_d = TX_BUSY;
            TX_BUSY: if (tx_char_done) state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        tx_start_ok = (state_q == TX_IDLE) && tx_start_req && (is_flow_char || lines_clear);
        tx_busy     = (state_q == TX_BUSY);
    end

    AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy && tx_start_req && !is_flow_char && cts_en && cts_n_s |-> !tx_start_ok); // R6
    AST_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start_req && tx_start_ok |=> tx_busy); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy && tx_char_done |=> !tx_busy); // R7
    AST_FLOW_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy && tx_start_req && is_flow_char |-> tx_start_ok); // R8
    AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy && !tx_char_done |=> tx_busy); // R9
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
    import uart_flow_pkg::*;
#(
    parameter int LVL_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rts_auto_en,
    input  logic [LVL_W-1:0] rts_upper,
    input  logic [LVL_W-1:0] rts_lower,
    input  logic             rts_sw,
    input  logic             dtr_auto_en,
    input  logic [LVL_W-1:0] dtr_upper,
    input  logic [LVL_W-1:0] dtr_lower,
    input  logic             dtr_sw,
    input  logic             cts_auto_en,
    input  logic             dsr_auto_en,
    input  logic             cts_n,
    input  logic             dsr_n,
    input  logic             tx_start_req,
    input  logic             is_flow_char,
    input  logic             tx_char_done,
    output logic             tx_start_ok,
    output logic             tx_busy,
    output logic             rts_n,
    output logic             dtr_n
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] lines_s;

    flow_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dsr_n, cts_n}),
        .q     (lines_s)
    );

    flow_rx_throttle #(.LVL_W(LVL_W)) u_rts (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (rts_auto_en),
        .level     (rx_level),
        .upper     (rts_upper),
        .lower     (rts_lower),
        .sw_assert (rts_sw),
        .pin_n     (rts_n)
    );

    flow_rx_throttle #(.LVL_W(LVL_W)) u_dtr (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (dtr_auto_en),
        .level     (rx_level),
        .upper     (dtr_upper),
        .lower     (dtr_lower),
        .sw_assert (dtr_sw),
        .pin_n     (dtr_n)
    );

    flow_tx_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .cts_en       (cts_auto_en),
        .dsr_en       (dsr_auto_en),
        .cts_n_s      (lines_s[0]),
        .dsr_n_s      (lines_s[1]),
        .tx_start_req (tx_start_req),
        .is_flow_char (is_flow_char),
        .tx_char_done (tx_char_done),
        .tx_start_ok  (tx_start_ok),
        .tx_busy      (tx_busy)
    );
endmodule

// File: tb/uart_flow_ctrl_bench.sv
`timescale 1ns/1ps
module uart_flow_ctrl_bench;
    localparam int LW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] rx_level = '0;
    logic          rts_auto_en = 1'b0, dtr_auto_en = 1'b0;
    logic [LW-1:0] rts_upper = '0, rts_lower = '0, dtr_upper = '0, dtr_lower = '0;
    logic          rts_sw = 1'b0, dtr_sw = 1'b0;
    logic          cts_auto_en = 1'b0, dsr_auto_en = 1'b0;
    logic          cts_n = 1'b1, dsr_n = 1'b1;
    logic          tx_start_req = 1'b0, is_flow_char = 1'b0, tx_char_done = 1'b0;
    logic          tx_start_ok, tx_busy, rts_n, dtr_n;

    int total = 0;
    int bad = 0;
    logic exp_r = 1'b1;
    logic exp_d = 1'b1;

    always #2 clk = ~clk;

    uart_flow_ctrl #(.LVL_W(LW)) u_uart_flow_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level),
        .rts_auto_en(rts_auto_en), .rts_upper(rts_upper), .rts_lower(rts_lower), .rts_sw(rts_sw),
        .dtr_auto_en(dtr_auto_en), .dtr_upper(dtr_upper), .dtr_lower(dtr_lower), .dtr_sw(dtr_sw),
        .cts_auto_en(cts_auto_en), .dsr_auto_en(dsr_auto_en), .cts_n(cts_n), .dsr_n(dsr_n),
        .tx_start_req(tx_start_req), .is_flow_char(is_flow_char), .tx_char_done(tx_char_done),
        .tx_start_ok(tx_start_ok), .tx_busy(tx_busy), .rts_n(rts_n), .dtr_n(dtr_n)
    );

    task automatic check(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic thr_next(logic cur, logic auto_on, logic [LW-1:0] lv,
                                      logic [LW-1:0] up, logic [LW-1:0] lo, logic sw);
        if (!auto_on) return !sw;
        if (lv >= up) return 1'b1;
        if (lv < lo)  return 1'b0;
        return cur;
    endfunction

    function automatic logic grant_exp(logic req, logic flow, logic ce, logic de,
                                       logic c, logic d);
        return req && (flow || ((!ce || !c) && (!de || !d)));
    endfunction

    // drive level at negedge, predict, check after the next rising edge
    task automatic rx_step(logic [LW-1:0] lv, string tag);
        rx_level = lv;
        exp_r = thr_next(exp_r, rts_auto_en, lv, rts_upper, rts_lower, rts_sw);
        exp_d = thr_next(exp_d, dtr_auto_en, lv, dtr_upper, dtr_lower, dtr_sw);
        tick();
        check({tag, " rts"}, rts_n, exp_r);
        check({tag, " dtr"}, dtr_n, exp_d);
    endtask

    task automatic tx_trial(logic ce, logic de, logic c, logic d, logic flow);
        logic e;
        cts_auto_en = ce; dsr_auto_en = de; cts_n = c; dsr_n = d;
        is_flow_char = flow; tx_start_req = 1'b0;
        tick(); tick();                      // two synchronizing edges
        tx_start_req = 1'b1;
        #1;
        e = grant_exp(1'b1, flow, ce, de, c, d);
        check(flow ? "R8 flow bypass" : "R6 gate", tx_start_ok, e);
        tick();
        if (e) begin
            check("R7 busy after grant", tx_busy, 1'b1);
            check("R7 no grant while busy", tx_start_ok, 1'b0);
            tx_start_req = 1'b0;
            cts_auto_en = 1'b1; dsr_auto_en = 1'b1; cts_n = 1'b1; dsr_n = 1'b1;
            tick(); tick(); tick();
            check("R9 no abort", tx_busy, 1'b1);
            tx_char_done = 1'b1;
            tick();
            tx_char_done = 1'b0;
            check("R7 done clears busy", tx_busy, 1'b0);
        end else begin
            check("R6 stays idle", tx_busy, 1'b0);
            tx_start_req = 1'b0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R1 rts reset", rts_n, 1'b1);
        check("R1 dtr reset", dtr_n, 1'b1);
        check("R1 busy reset", tx_busy, 1'b0);
        check("R1 ok reset", tx_start_ok, 1'b0);
        rst_n = 1'b1;
        tick();
        check("R1 rts after reset", rts_n, 1'b1);
        check("R1 dtr after reset", dtr_n, 1'b1);

        // directed hysteresis
        rts_auto_en = 1'b1; rts_upper = 7'd10; rts_lower = 7'd4;
        dtr_auto_en = 1'b1; dtr_upper = 7'd20; dtr_lower = 7'd8;
        rx_step(7'd2,  "R3 below both");
        rx_step(7'd12, "R2 rts over upper, R4 dtr between");
        rx_step(7'd7,  "R4 hold high");
        rx_step(7'd10, "R2 level equals upper");
        rx_step(7'd25, "R2 both over");
        rx_step(7'd9,  "R4 hold");
        rx_step(7'd3,  "R3 release");
        rx_step(7'd6,  "R4 hold low");
        // manual mode ignores level
        rts_auto_en = 1'b0; rts_sw = 1'b1;
        rx_step(7'd100, "R5 sw assert");
        rts_sw = 1'b0;
        rx_step(7'd0, "R5 sw deassert");

        // random throttle stimulus
        for (int blk = 0; blk < 8; blk++) begin
            rts_auto_en = 1'($urandom_range(0, 3) != 0);
            dtr_auto_en = 1'($urandom_range(0, 3) != 0);
            rts_upper = 7'($urandom_range(20, 100));
            rts_lower = 7'($urandom_range(0, 40));
            dtr_upper = 7'($urandom_range(20, 100));
            dtr_lower = 7'($urandom_range(0, 40));
            for (int k = 0; k < 40; k++) begin
                rts_sw = 1'($urandom_range(0, 1));
                dtr_sw = 1'($urandom_range(0, 1));
                rx_step(7'($urandom_range(0, 127)), "R2/R3/R4/R5 random");
            end
        end

        // directed transmit gating
        tx_trial(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);   // CTS blocks
        tx_trial(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);   // DSR blocks
        tx_trial(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);   // both disabled: lines ignored
        tx_trial(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);   // flow char bypass
        tx_trial(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);   // both clear
        for (int k = 0; k < 60; k++) begin
            tx_trial(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 3) == 0));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule